// File: doc/BRIEF.md
# Two-Frame Serial Word Transmitter

This block sends one 16-bit word on an asynchronous serial line as two character frames with no gap between them. Each frame carries one byte of the word and is framed by a low start bit, a parity bit and a high stop bit. A selectable bit order decides two things together: which byte of the word goes out first, and whether each byte is sent from its least or most significant bit. A second select chooses even or odd parity, which is computed for each frame on its own byte.

Words enter through a single 16-bit write strobe; there is no narrower write path. A written word waits in a holding register. It then moves to a sub buffer, and from there into the shift register. Because of this three-stage path, software can queue the next word while the current one is on the line, and consecutive words leave without idle time. Each time the holding register hands its word on and becomes empty, a one-cycle interrupt pulse is raised. A write that arrives while the holding register is still occupied is dropped and sets a sticky overrun flag. Bit timing comes from an external baud tick, and each bit lasts a fixed number of ticks.

Top module: `dual_frame_uart_tx`

## Requirements
- R1: After reset the serial line is high, and busy, the interrupt pulse and the overrun flag are all low.
- R2: Each accepted word produces 22 bit times on the line: frame one (start 0, 8 data bits, parity, stop 1), then frame two in the same layout, with frame two's start bit directly after frame one's stop bit.
- R3: With msb_first = 0, the first frame carries wr_data[7:0] sent bit 0 first, and the second frame carries wr_data[15:8] sent bit 8 first.
- R4: With msb_first = 1, the first frame carries wr_data[15:8] sent bit 15 first, and the second frame carries wr_data[7:0] sent bit 7 first.
- R5: Each frame's parity bit covers only that frame's 8 data bits. With parity_odd = 0 the data plus parity hold an even number of ones; with parity_odd = 1 they hold an odd number.
- R6: Every bit stays on the line for exactly 16 baud ticks, and the line does not change in a cycle that follows a cycle with no baud tick.
- R7: txe_irq pulses high for exactly one cycle each time the holding register passes its word on. From idle, it pulses in the second cycle after the write cycle, and busy rises one cycle later.
- R8: A word queued while another is being sent starts directly after that word's final stop bit, and busy stays high in between.
- R9: A write while the holding register is full is ignored, so that word is never sent. It sets overrun, which stays high until reset. Writes into an empty holding register do not set overrun.
- R10: busy is high from the first start bit to the end of the last stop bit of the last queued word, then falls. The line is high whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write strobe for wr_data |
| wr_data | input | 16 | Word to transmit |
| msb_first | input | 1 | 1: high byte first, each byte MSB first; 0: low byte first, LSB first |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| baud_tick | input | 1 | One-cycle bit-timing tick |
| tx_line | output | 1 | Serial output, idles high |
| txe_irq | output | 1 | One-cycle pulse when the holding register empties |
| busy | output | 1 | A word is on the line |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
The bench aims at the byte swap and bit reversal that bit order brings. If the two were mixed up, the table patterns that have different high and low bytes would come out wrong. All-ones, all-zeros and single-bit words expose a parity that is inverted or computed across the whole word. A burst of four writes checks two things. A write accepted one cycle too early would appear on the line in place of a queued word. A reload gap would shift every sampled bit after the first word. The bench also measures the start bit's length and runs a slow-tick pass, which catches an off-by-one in the tick count.

// File: rtl/dual_frame_uart_tx_pkg.sv
// Package: shared sizes for the two-frame transmitter.
// Assumes one character is 8 bits and a word holds exactly two characters.
package dual_frame_uart_tx_pkg;
    localparam int CHAR_W      = 8;
    localparam int WORD_W      = 2 * CHAR_W;
    localparam int FRAME_W     = CHAR_W + 3;     // start, data, parity, stop
    localparam int WORD_FRAMES = 2;
    localparam int LINE_BITS   = WORD_FRAMES * FRAME_W;
endpackage

// File: rtl/dftx_queue.sv
// Holding register plus sub buffer in front of the shift register.
// Does: accepts a word when the holding register is empty, forwards it to the
// sub buffer when that is free (or freed in the same cycle), pulses the
// interrupt on each hand-over and flags writes into a full holding register.
// Assumes: take is only asserted while sub_full is high.
module dftx_queue #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             take,
    output logic [WIDTH-1:0] sub_data,
    output logic             sub_full,
    output logic             txe_irq,
    output logic             overrun
);
    logic             hold_full;
    logic [WIDTH-1:0] hold_data;
    logic             move;

    // Hand-over happens when the sub buffer is empty or being drained now.
    assign move = hold_full && (!sub_full || take);

    // Holding register: fill on a write into an empty slot, clear on hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (wr_valid && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end else if (move) begin
            hold_full <= 1'b0;
        end
    end

    // Sub buffer: load from the holding register, empty when the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_full <= 1'b0;
            sub_data <= '0;
        end else if (move) begin
            sub_full <= 1'b1;
            sub_data <= hold_data;
        end else if (take) begin
            sub_full <= 1'b0;
        end
    end

    // Interrupt pulse and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txe_irq <= 1'b0;
            overrun <= 1'b0;
        end else begin
            txe_irq <= move;
            if (wr_valid && hold_full) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/dftx_framer.sv
// Combinational frame builder.
// Does: turns one word into the line pattern for two frames, bit 0 of the
// output being the first bit on the line. The bit order picks both the byte
// sent first and the bit order inside each byte; parity is per frame.
// Assumes: WIDTH is twice CHAR_W.
module dftx_framer #(
    parameter int CHAR_W = 8
) (
    input  logic [2*CHAR_W-1:0]      word,
    input  logic                     msb_first,
    input  logic                     parity_odd,
    output logic [2*(CHAR_W+3)-1:0]  line_bits
);
    localparam int FW = CHAR_W + 3;

    for (genvar f = 0; f < 2; f++) begin : g_frame
        logic [CHAR_W-1:0] chr;
        logic [CHAR_W-1:0] ordered;
        logic              par;

        // Frame 0 takes the low byte in LSB-first mode, the high byte otherwise.
        if (f == 0) begin : g_first
            assign chr = msb_first ? word[2*CHAR_W-1:CHAR_W] : word[CHAR_W-1:0];
        end else begin : g_second
            assign chr = msb_first ? word[CHAR_W-1:0] : word[2*CHAR_W-1:CHAR_W];
        end

        for (genvar i = 0; i < CHAR_W; i++) begin : g_bit
            assign ordered[i] = msb_first ? chr[CHAR_W-1-i] : chr[i];
        end

        assign par = (^chr) ^ parity_odd;
        assign line_bits[f*FW +: FW] = {1'b1, par, ordered, 1'b0};
    end
endmodule

// File: rtl/dftx_shifter.sv
// Bit-timing shift engine.
// Does: loads a full two-frame pattern, holds each bit for TICKS baud ticks,
// and reloads the next pattern on the last tick of the final stop bit.
// Assumes: baud_tick is a single-cycle strobe; the pattern is sent bit 0 first.
module dftx_shifter #(
    parameter int LEN   = 22,
    parameter int TICKS = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           baud_tick,
    input  logic           pend,
    input  logic [LEN-1:0] pattern,
    output logic           take,
    output logic           tx_line,
    output logic           busy
);
    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam int BW = $clog2(LEN);
    localparam logic [TW-1:0] TLAST = TW'(TICKS - 1);
    localparam logic [BW-1:0] BLAST = BW'(LEN - 1);

    logic           active;
    logic [LEN-1:0] shreg;
    logic [TW-1:0]  tick_cnt;
    logic [BW-1:0]  bit_idx;
    logic           bit_done;
    logic           word_end;

    assign bit_done = active && baud_tick && (tick_cnt == TLAST);
    assign word_end = bit_done && (bit_idx == BLAST);
    assign take     = pend && (!active || word_end);

    // Load, count ticks, shift one bit per TICKS ticks, stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            shreg    <= '1;
            tick_cnt <= '0;
            bit_idx  <= '0;
        end else if (take) begin
            active   <= 1'b1;
            shreg    <= pattern;
            tick_cnt <= '0;
            bit_idx  <= '0;
        end else if (word_end) begin
            active   <= 1'b0;
            tick_cnt <= '0;
        end else if (bit_done) begin
            tick_cnt <= '0;
            shreg    <= {1'b1, shreg[LEN-1:1]};
            bit_idx  <= bit_idx + 1'b1;
        end else if (active && baud_tick) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    assign tx_line = active ? shreg[0] : 1'b1;
    assign busy    = active;
endmodule

// File: rtl/dual_frame_uart_tx.sv
// Top: two-frame serial word transmitter.
// Does: queues 16-bit words through a holding register and sub buffer, frames
// each into two back-to-back characters and shifts them out at the baud rate.
// Assumes: mode inputs are sampled when a word enters the shift register.
module dual_frame_uart_tx
    import dual_frame_uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              msb_first,
    input  logic              parity_odd,
    input  logic              baud_tick,
    output logic              tx_line,
    output logic              txe_irq,
    output logic              busy,
    output logic              overrun
);
    logic [WORD_W-1:0]    sub_data;
    logic                 sub_full;
    logic                 take;
    logic [LINE_BITS-1:0] pattern;

    dftx_queue #(.WIDTH(WORD_W)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .sub_data (sub_data),
        .sub_full (sub_full),
        .txe_irq  (txe_irq),
        .overrun  (overrun)
    );

    dftx_framer #(.CHAR_W(CHAR_W)) u_framer (
        .word       (sub_data),
        .msb_first  (msb_first),
        .parity_odd (parity_odd),
        .line_bits  (pattern)
    );

    dftx_shifter #(.LEN(LINE_BITS), .TICKS(TICKS_PER_BIT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .pend      (sub_full),
        .pattern   (pattern),
        .take      (take),
        .tx_line   (tx_line),
        .busy      (busy)
    );
endmodule

// File: rtl/dual_frame_uart_tx_checker.sv
// Checker: temporal properties of the transmitter's ports, bound to the top.
module dual_frame_uart_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic baud_tick,
    input logic tx_line,
    input logic txe_irq,
    input logic busy,
    input logic overrun
);
    p_idle_line_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_line);

    p_hold_without_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(baud_tick)) |-> (busy && $stable(tx_line)));

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        txe_irq |=> !txe_irq);

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(wr_valid));

    p_busy_end_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(baud_tick));
endmodule

bind dual_frame_uart_tx dual_frame_uart_tx_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .baud_tick (baud_tick),
    .tx_line   (tx_line),
    .txe_irq   (txe_irq),
    .busy      (busy),
    .overrun   (overrun)
);

// File: tb/tb_dual_frame_uart_tx.sv
module tb_dual_frame_uart_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        msb_first = 1'b0;
    logic        parity_odd = 1'b0;
    logic        baud_tick = 1'b1;
    logic        tx_line, txe_irq, busy, overrun;

    int errors = 0;
    int checks = 0;
    int irq_cnt = 0;
    int tick_div = 1;
    int tick_ctr = 0;

    always #4 clk = ~clk;

    dual_frame_uart_tx dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .msb_first(msb_first), .parity_odd(parity_odd), .baud_tick(baud_tick),
        .tx_line(tx_line), .txe_irq(txe_irq), .busy(busy), .overrun(overrun)
    );

    // Baud tick every tick_div cycles, driven away from the active edge.
    always @(negedge clk) begin
        baud_tick = (tick_ctr == 0);
        tick_ctr  = (tick_ctr + 1 >= tick_div) ? 0 : tick_ctr + 1;
    end

    always @(negedge clk) if (txe_irq === 1'b1) irq_cnt++;

    // data, msb_first, parity_odd, first byte on line, second byte on line
    localparam logic [33:0] VEC [6] = '{
        {16'hA55A, 1'b0, 1'b0, 8'h5A, 8'hA5},
        {16'h1234, 1'b1, 1'b0, 8'h12, 8'h34},
        {16'h00FF, 1'b0, 1'b1, 8'hFF, 8'h00},
        {16'h8001, 1'b1, 1'b1, 8'h80, 8'h01},
        {16'hFFFF, 1'b0, 1'b0, 8'hFF, 8'hFF},
        {16'h0000, 1'b1, 1'b1, 8'h00, 8'h00}
    };

    function automatic logic [10:0] exp_frame(input logic [7:0] b, input logic msb, input logic odd);
        logic [10:0] f;
        int ones = 0;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            f[1+i] = msb ? b[7-i] : b[i];
            if (b[i]) ones++;
        end
        f[9]  = odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
        f[10] = 1'b1;
        return f;
    endfunction

    function automatic logic [21:0] exp_word(input logic [15:0] d, input logic msb, input logic odd);
        logic [7:0] a, b;
        a = msb ? d[15:8] : d[7:0];
        b = msb ? d[7:0]  : d[15:8];
        return {exp_frame(b, msb, odd), exp_frame(a, msb, odd)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 3000 && busy; n++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Sample the line mid-bit from the first negedge with busy high.
    task automatic capture(input int nbits, input int half, input int period,
                           output logic [65:0] got, output bit busy_ok);
        got = '0;
        busy_ok = 1'b1;
        for (int n = 0; n < 200 && !busy; n++) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            repeat (k == 0 ? half : period) @(negedge clk);
            got[k] = tx_line;
            if (!busy) busy_ok = 1'b0;
        end
    endtask

    initial begin
        logic [65:0] got;
        logic [65:0] exp;
        bit          bok;
        int          low_cnt;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(tx_line === 1'b1, "R1 line idle", 66'(tx_line), 66'd1);
        check(busy === 1'b0, "R1 busy", 66'(busy), 66'd0);
        check(txe_irq === 1'b0, "R1 irq", 66'(txe_irq), 66'd0);
        check(overrun === 1'b0, "R1 overrun", 66'(overrun), 66'd0);

        // R7 hand-over pulse timing, R6 start-bit length
        write_word(16'h0001);
        check(txe_irq === 1'b0 && busy === 1'b0, "R7 cycle after write", 66'({txe_irq, busy}), 66'b00);
        @(negedge clk);
        check(txe_irq === 1'b1 && busy === 1'b0, "R7 pulse", 66'({txe_irq, busy}), 66'b10);
        @(negedge clk);
        check(txe_irq === 1'b0 && busy === 1'b1 && tx_line === 1'b0, "R7 busy rises",
              66'({txe_irq, busy, tx_line}), 66'b010);
        low_cnt = 0;
        while (tx_line === 1'b0 && low_cnt < 100) begin
            low_cnt++;
            @(negedge clk);
        end
        check(low_cnt == 16, "R6 start bit length", 66'(low_cnt), 66'd16);
        wait_idle();

        // Table: R2 R3 R4 R5 patterns, R10 end of word
        foreach (VEC[v]) begin
            msb_first  = VEC[v][17];
            parity_odd = VEC[v][16];
            exp = 66'(exp_word(VEC[v][33:18], VEC[v][17], VEC[v][16]));
            check(exp[8:1] == (VEC[v][17] ? {<<{VEC[v][15:8]}} : VEC[v][15:8]),
                  "R3 R4 table first byte", 66'(exp[8:1]), 66'(VEC[v][15:8]));
            fork
                write_word(VEC[v][33:18]);
                capture(22, 8, 16, got, bok);
            join
            check(got[21:0] == exp[21:0], VEC[v][17] ? "R4 R2 R5 msb-first word" : "R3 R2 R5 lsb-first word",
                  got, exp);
            check(bok, "R10 busy through word", 66'(bok), 66'd1);
            wait_idle();
            check(busy === 1'b0 && tx_line === 1'b1, "R10 idle after word",
                  66'({busy, tx_line}), 66'b01);
        end

        // R6: slow ticks, one every third cycle
        tick_div   = 3;
        msb_first  = 1'b1;
        parity_odd = 1'b1;
        fork
            write_word(16'hC3A6);
            capture(22, 24, 48, got, bok);
        join
        exp = 66'(exp_word(16'hC3A6, 1'b1, 1'b1));
        check(got[21:0] == exp[21:0], "R6 slow tick word", got, exp);
        wait_idle();
        tick_div = 1;

        // R8 back-to-back, R9 overrun
        msb_first  = 1'b0;
        parity_odd = 1'b0;
        irq_cnt    = 0;
        fork
            capture(66, 8, 16, got, bok);
            begin
                write_word(16'h1357);
                repeat (3) @(negedge clk);
                write_word(16'h2468);
                write_word(16'h9ABC);
                check(overrun === 1'b0, "R9 no overrun on empty slot", 66'(overrun), 66'd0);
                write_word(16'hFFFF);
                check(overrun === 1'b1, "R9 overrun set", 66'(overrun), 66'd1);
            end
        join
        exp = {exp_word(16'h9ABC, 1'b0, 1'b0), exp_word(16'h2468, 1'b0, 1'b0), exp_word(16'h1357, 1'b0, 1'b0)};
        check(got == exp, "R8 R9 three queued words, dropped write absent", got, exp);
        check(bok, "R8 busy held across words", 66'(bok), 66'd1);
        repeat (10) @(negedge clk);
        check(busy === 1'b0, "R10 busy falls after last stop", 66'(busy), 66'd0);
        check(tx_line === 1'b1, "R9 dropped word not sent", 66'(tx_line), 66'd1);
        wait_idle();
        check(irq_cnt == 3, "R7 one pulse per hand-over", 66'(irq_cnt), 66'd3);
        check(overrun === 1'b1, "R9 overrun sticky", 66'(overrun), 66'd1);

        // R1: reset clears overrun
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(overrun === 1'b0 && busy === 1'b0, "R1 reset clears", 66'({overrun, busy}), 66'b00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule